// File: doc/BRIEF.md
# Rejected-Interrupt Replay Scanner

An interrupt presenter sometimes turns an interrupt away, for example because a higher-priority one already holds the target. This block keeps a record of every such rejection and replays them later on request. Each replay goes downstream as a forced retry, and a forced retry is delivered whatever state the downstream gate has stored.

The record is a two-level bitmap. A flat array holds one bit per local source. A summary vector holds one bit per array word and flags the words that may contain entries. A reject strobe carries an absolute interrupt number. The block subtracts the configured base from that number, and if the result falls inside the array it sets the matching bit and its summary bit. A resend strobe starts a scan. The scan walks the summary from low words to high, skips every word whose summary flag is clear, and clears a word's flag as it enters that word. It then offers the word's set bits one at a time, lowest first, on a valid/ready retry port.

Rejects that arrive while a scan runs are merged into the bitmap. An entry that lands behind the scan position waits for the next resend. An entry that lands ahead of it is replayed in the same pass.

Top module: `reject_replay`

## Requirements
- R1: The local source of a reject is `rej_num - offset`, taken modulo 2^IRQ_W. Its bits [10:6] select one of 32 words and bits [5:0] select one of 64 bits in that word. A replay reports the same 11-bit value, word*64+bit, on `retry_src`.
- R2: A reject in range sets its bitmap bit and the summary bit of its word at the next clock edge. The entry is then replayed by the next resend that reaches it.
- R3: A resend that arrives while idle with an all-zero summary changes nothing: `busy` and `retry_valid` stay 0.
- R4: A scan visits words in ascending order. Each word whose summary bit is set costs one select cycle, in which its summary bit is cleared. Words whose summary bit is clear are skipped and produce no retry.
- R5: Inside a word, set bits are offered in ascending bit order. A bit is cleared when its retry is accepted, and it is not offered again in the same pass.
- R6: Reset, active low and asynchronous, clears every bitmap word and the summary, and returns the scanner to idle with `busy` and `retry_valid` at 0.
- R7: A reject whose local source is 2048 or more is ignored. This includes a number below the offset, which wraps to a large value.
- R8: A reject that arrives during a scan is recorded. If its word lies below the word being scanned, or it is in that word below the current bit position, it waits for the next resend. Otherwise it is replayed in the current pass. A reject that hits a bit in the cycle that bit is accepted leaves the bit set.
- R9: At most one retry is offered per cycle. While `retry_valid` is high and `retry_ready` is low, `retry_valid` and `retry_src` hold their values.
- R10: A resend that arrives while a scan is running is ignored.
- R11: A resend accepted at an edge raises `busy` in the following cycle. That cycle is a select cycle with no retry, so the first retry becomes valid one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offset | input | IRQ_W | Base number subtracted from every rejected interrupt number |
| rej_valid | input | 1 | Reject strobe, one per cycle |
| rej_num | input | IRQ_W | Absolute number of the rejected interrupt |
| resend | input | 1 | Request to replay everything recorded |
| retry_ready | input | 1 | Downstream accepts the offered retry |
| retry_valid | output | 1 | A forced retry is offered |
| retry_src | output | SRC_W | Local source of the offered retry (word*64+bit) |
| busy | output | 1 | A scan is in progress |

## Verification
A reject becomes part of the bitmap at the edge that samples it. A resend accepted at edge N moves the scanner into a select cycle, so `busy` is visible right after N and the first retry right after edge N+1. After that, each accepted retry and each word exit costs exactly one edge. The bench keeps a behavioural model that advances at every rising edge from the same inputs, and compares `busy`, `retry_valid` and `retry_src` with the model at every falling edge. Directed checks sample at the falling edge that falls the counted number of edges after the stimulus. Separate lists of the accepted sources check the replay order and pass membership for the base-offset, out-of-range, merge-during-scan and mid-scan-reset cases.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
   typedef enum logic [1:0] {
      SC_IDLE  = 2'd0,
      SC_PICK  = 2'd1,
      SC_DRAIN = 2'd2
   } scan_state_e;
endpackage

// File: rtl/rrb_first_set.sv
// Lowest set bit of a vector at or above a floor index.
module rrb_first_set #(
   parameter int N    = 64,
   parameter int IW   = $clog2(N),
   parameter int FW   = IW + 1
) (
   input  logic [N-1:0]  vec,
   input  logic [FW-1:0] floor_idx,
   output logic          found,
   output logic [IW-1:0] idx
);
   initial assert (N == (1 << IW)) else $fatal(1, "rrb_first_set: N must be a power of two");

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i] && (i >= int'(floor_idx))) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/rrb_decode.sv
// Maps an absolute interrupt number to a word/bit position of the bitmap.
module rrb_decode #(
   parameter int IRQ_W = 32,
   parameter int SRC_W = 11,
   parameter int WB_W  = 6,
   localparam int WW_W = SRC_W - WB_W
) (
   input  logic             rej_valid,
   input  logic [IRQ_W-1:0] rej_num,
   input  logic [IRQ_W-1:0] offset,
   output logic             set_en,
   output logic [WW_W-1:0]  set_word,
   output logic [WB_W-1:0]  set_bit
);
   initial assert (IRQ_W >= SRC_W) else $fatal(1, "rrb_decode: IRQ_W narrower than source index");
   initial assert (SRC_W > WB_W) else $fatal(1, "rrb_decode: need at least two words");

   logic [IRQ_W-1:0] local_src;
   logic             in_range;

   assign local_src = rej_num - offset;

   generate
      if (IRQ_W > SRC_W) begin : g_wide
         assign in_range = ~|local_src[IRQ_W-1:SRC_W];
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate

   assign set_en   = rej_valid & in_range;
   assign set_word = local_src[SRC_W-1:WB_W];
   assign set_bit  = local_src[WB_W-1:0];
endmodule

// File: rtl/rrb_store.sv
// Bitmap words plus one summary flag per word; set has priority over clear.
module rrb_store #(
   parameter int NW   = 32,
   parameter int WB   = 64,
   localparam int WW_W = $clog2(NW),
   localparam int WB_W = $clog2(WB)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [WW_W-1:0] set_word,
   input  logic [WB_W-1:0] set_bit,
   input  logic            clr_en,
   input  logic [WW_W-1:0] clr_word,
   input  logic [WB_W-1:0] clr_bit,
   input  logic            sum_clr_en,
   input  logic [WW_W-1:0] sum_clr_word,
   input  logic [WW_W-1:0] rd_sel,
   output logic [WB-1:0]   rd_data,
   output logic [NW-1:0]   sum_o
);
   initial assert (NW == (1 << WW_W)) else $fatal(1, "rrb_store: NW must be a power of two");
   initial assert (WB == (1 << WB_W)) else $fatal(1, "rrb_store: WB must be a power of two");

   logic [WB-1:0] rows [NW];

   generate
      for (genvar w = 0; w < NW; w++) begin : g_word
         logic [WB-1:0] row_q;
         logic          flag_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_q <= '0;
            end else begin
               if (clr_en && (clr_word == WW_W'(w))) row_q[clr_bit] <= 1'b0;
               if (set_en && (set_word == WW_W'(w))) row_q[set_bit] <= 1'b1;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (set_en && (set_word == WW_W'(w))) begin
               flag_q <= 1'b1;
            end else if (sum_clr_en && (sum_clr_word == WW_W'(w))) begin
               flag_q <= 1'b0;
            end
         end

         assign rows[w]  = row_q;
         assign sum_o[w] = flag_q;
      end
   endgenerate

   assign rd_data = rows[rd_sel];

   // R2
   sum_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> sum_o[$past(set_word)]);
endmodule

// File: rtl/rrb_scan.sv
// Resend scanner: pick next flagged word, then drain its bits in ascending order.
module rrb_scan
   import rrb_pkg::*;
#(
   parameter int NW   = 32,
   parameter int WB   = 64,
   localparam int WW_W = $clog2(NW),
   localparam int WB_W = $clog2(WB),
   localparam int SRC_W = WW_W + WB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resend,
   input  logic             retry_ready,
   input  logic [NW-1:0]    sum,
   input  logic [WB-1:0]    rd_data,
   output logic [WW_W-1:0]  rd_sel,
   output logic             retry_valid,
   output logic [SRC_W-1:0] retry_src,
   output logic             busy,
   output logic             clr_en,
   output logic [WW_W-1:0]  clr_word,
   output logic [WB_W-1:0]  clr_bit,
   output logic             sum_clr_en,
   output logic [WW_W-1:0]  sum_clr_word
);
   scan_state_e       state_q;
   logic [WW_W-1:0]   wptr_q;
   logic [WB_W:0]     bptr_q;

   logic              word_found;
   logic [WW_W-1:0]   word_idx;
   logic              bit_found;
   logic [WB_W-1:0]   bit_idx;

   rrb_first_set #(.N(NW)) u_word_pick (
      .vec       (sum),
      .floor_idx ({1'b0, wptr_q}),
      .found     (word_found),
      .idx       (word_idx)
   );

   rrb_first_set #(.N(WB)) u_bit_pick (
      .vec       (rd_data),
      .floor_idx (bptr_q),
      .found     (bit_found),
      .idx       (bit_idx)
   );

   always_comb begin
      rd_sel       = wptr_q;
      busy         = (state_q != SC_IDLE);
      retry_valid  = (state_q == SC_DRAIN) && bit_found;
      retry_src    = {wptr_q, bit_idx};
      clr_en       = retry_valid && retry_ready;
      clr_word     = wptr_q;
      clr_bit      = bit_idx;
      sum_clr_en   = (state_q == SC_PICK) && word_found;
      sum_clr_word = word_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SC_IDLE;
         wptr_q  <= '0;
         bptr_q  <= '0;
      end else begin
         case (state_q)
            SC_IDLE: begin
               if (resend && (|sum)) begin
                  state_q <= SC_PICK;
                  wptr_q  <= '0;
               end
            end
            SC_PICK: begin
               if (word_found) begin
                  wptr_q  <= word_idx;
                  bptr_q  <= '0;
                  state_q <= SC_DRAIN;
               end else begin
                  state_q <= SC_IDLE;
               end
            end
            SC_DRAIN: begin
               if (bit_found) begin
                  bptr_q <= {1'b0, bit_idx} + (WB_W + 1)'(retry_ready);
               end else if (wptr_q == WW_W'(NW - 1)) begin
                  state_q <= SC_IDLE;
               end else begin
                  wptr_q  <= wptr_q + 1'b1;
                  state_q <= SC_PICK;
               end
            end
            default: state_q <= SC_IDLE;
         endcase
      end
   end

   // R3
   empty_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SC_IDLE && resend && !(|sum)) |=> !busy);

   // R11
   start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SC_IDLE && resend && (|sum)) |=> (busy && !retry_valid));

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_valid && !retry_ready) |=> (retry_valid && $stable(retry_src)));

   // R5
   no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !(retry_valid && (retry_src == $past(retry_src))));
endmodule

// File: rtl/reject_replay.sv
module reject_replay #(
   parameter int IRQ_W     = 32,
   parameter int NUM_WORDS = 32,
   parameter int WORD_BITS = 64,
   localparam int WW_W  = $clog2(NUM_WORDS),
   localparam int WB_W  = $clog2(WORD_BITS),
   localparam int SRC_W = WW_W + WB_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] offset,
   input  logic             rej_valid,
   input  logic [IRQ_W-1:0] rej_num,
   input  logic             resend,
   input  logic             retry_ready,
   output logic             retry_valid,
   output logic [SRC_W-1:0] retry_src,
   output logic             busy
);
   logic            set_en;
   logic [WW_W-1:0] set_word;
   logic [WB_W-1:0] set_bit;
   logic            clr_en;
   logic [WW_W-1:0] clr_word;
   logic [WB_W-1:0] clr_bit;
   logic            sum_clr_en;
   logic [WW_W-1:0] sum_clr_word;
   logic [WW_W-1:0] rd_sel;
   logic [WORD_BITS-1:0] rd_data;
   logic [NUM_WORDS-1:0] sum;

   rrb_decode #(.IRQ_W(IRQ_W), .SRC_W(SRC_W), .WB_W(WB_W)) u_decode (
      .rej_valid (rej_valid),
      .rej_num   (rej_num),
      .offset    (offset),
      .set_en    (set_en),
      .set_word  (set_word),
      .set_bit   (set_bit)
   );

   rrb_store #(.NW(NUM_WORDS), .WB(WORD_BITS)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_en       (set_en),
      .set_word     (set_word),
      .set_bit      (set_bit),
      .clr_en       (clr_en),
      .clr_word     (clr_word),
      .clr_bit      (clr_bit),
      .sum_clr_en   (sum_clr_en),
      .sum_clr_word (sum_clr_word),
      .rd_sel       (rd_sel),
      .rd_data      (rd_data),
      .sum_o        (sum)
   );

   rrb_scan #(.NW(NUM_WORDS), .WB(WORD_BITS)) u_scan (
      .clk          (clk),
      .rst_n        (rst_n),
      .resend       (resend),
      .retry_ready  (retry_ready),
      .sum          (sum),
      .rd_data      (rd_data),
      .rd_sel       (rd_sel),
      .retry_valid  (retry_valid),
      .retry_src    (retry_src),
      .busy         (busy),
      .clr_en       (clr_en),
      .clr_word     (clr_word),
      .clr_bit      (clr_bit),
      .sum_clr_en   (sum_clr_en),
      .sum_clr_word (sum_clr_word)
   );

   // R7
   wrap_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rej_valid && (rej_num < offset)) |-> !set_en);
endmodule

// File: tb/reject_replay_tb.sv
`timescale 1ns/1ps
module reject_replay_tb;
   localparam int NSRC = 2048;
   localparam int WBITS = 64;
   localparam int NWRD = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] offset = '0;
   logic        rej_valid = 1'b0;
   logic [31:0] rej_num = '0;
   logic        resend = 1'b0;
   logic        retry_ready = 1'b1;
   logic        retry_valid;
   logic [10:0] retry_src;
   logic        busy;

   int checks = 0;
   int errors = 0;
   string phase = "R6 reset";
   int got_q[$];

   bit m_bits [NSRC];
   bit m_sum  [NWRD];
   int m_state = 0;
   int m_w = 0;
   int m_b = 0;

   always #10 clk = ~clk;

   reject_replay u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .offset      (offset),
      .rej_valid   (rej_valid),
      .rej_num     (rej_num),
      .resend      (resend),
      .retry_ready (retry_ready),
      .retry_valid (retry_valid),
      .retry_src   (retry_src),
      .busy        (busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic void model_out(output bit v, output int s);
      v = 1'b0;
      s = 0;
      if (m_state == 2) begin
         for (int j = m_b; j < WBITS; j++) begin
            if (m_bits[m_w * WBITS + j]) begin
               v = 1'b1;
               s = m_w * WBITS + j;
               break;
            end
         end
      end
   endfunction

   function automatic bit any_sum();
      for (int w = 0; w < NWRD; w++) if (m_sum[w]) return 1'b1;
      return 1'b0;
   endfunction

   // reference model advances on every rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSRC; i++) m_bits[i] = 1'b0;
         for (int w = 0; w < NWRD; w++) m_sum[w] = 1'b0;
         m_state = 0;
         m_w = 0;
         m_b = 0;
      end else begin
         bit v;
         int s;
         int f;
         logic [31:0] loc;
         model_out(v, s);
         loc = rej_num - offset;
         case (m_state)
            0: if (resend && any_sum()) begin m_state = 1; m_w = 0; end
            1: begin
               f = -1;
               for (int w = m_w; w < NWRD; w++) if (m_sum[w]) begin f = w; break; end
               if (f < 0) m_state = 0;
               else begin m_w = f; m_b = 0; m_sum[f] = 1'b0; m_state = 2; end
            end
            default: begin
               if (v) begin
                  if (retry_ready) begin
                     m_bits[s] = 1'b0;
                     got_q.push_back(s);
                     m_b = (s % WBITS) + 1;
                  end else begin
                     m_b = s % WBITS;
                  end
               end else if (m_w == NWRD - 1) begin
                  m_state = 0;
               end else begin
                  m_w = m_w + 1;
                  m_state = 1;
               end
            end
         endcase
         if (rej_valid && (loc < NSRC)) begin
            m_bits[loc] = 1'b1;
            m_sum[loc / WBITS] = 1'b1;
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit v;
         int s;
         model_out(v, s);
         chk({phase, " valid"}, int'(retry_valid), int'(v));
         chk({phase, " busy"}, int'(busy), (m_state != 0) ? 1 : 0);
         if (v) chk({phase, " src"}, int'(retry_src), s);
      end
   end

   task automatic step(input logic rv, input logic [31:0] num, input logic rs, input logic rd);
      @(negedge clk);
      #1;
      rej_valid = rv;
      rej_num = num;
      resend = rs;
      retry_ready = rd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 32'd0, 1'b0, 1'b1);
   endtask

   task automatic rej(input int loc);
      step(1'b1, offset + 32'(loc), 1'b0, 1'b1);
   endtask

   task automatic check_list(input string tag, input int exp[$]);
      chk({tag, " count"}, got_q.size(), exp.size());
      for (int i = 0; i < exp.size() && i < got_q.size(); i++)
         chk({tag, " order"}, got_q[i], exp[i]);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int exp_q[$];
      offset = 32'd100;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 rst_n = 1'b1;
      // R6: reset state at the ports
      @(negedge clk);
      chk("R6 reset busy", int'(busy), 0);
      chk("R6 reset valid", int'(retry_valid), 0);

      // R3: resend with nothing recorded
      phase = "R3 empty resend";
      step(1'b0, 32'd0, 1'b1, 1'b1);
      idle(1);
      chk("R3 busy stays low", int'(busy), 0);
      idle(3);

      // R1 R2 R4 R5 R11: base offset, sparse words, ascending replay
      phase = "R1 R4 replay";
      got_q.delete();
      rej(2047); rej(130); rej(0); rej(64); rej(63);
      idle(1);
      step(1'b0, 32'd0, 1'b1, 1'b1);
      idle(1);
      chk("R11 busy in select cycle", int'(busy), 1);
      chk("R11 no retry in select cycle", int'(retry_valid), 0);
      idle(1);
      chk("R11 first retry valid", int'(retry_valid), 1);
      chk("R1 first retry source", int'(retry_src), 0);
      idle(40);
      exp_q = '{0, 63, 64, 130, 2047};
      check_list("R2 R4 R5 pass", exp_q);

      // R5: bits were cleared, second resend replays nothing
      phase = "R5 second pass";
      got_q.delete();
      step(1'b0, 32'd0, 1'b1, 1'b1);
      idle(10);
      chk("R5 nothing replayed twice", got_q.size(), 0);

      // R7: out-of-range and wrapped numbers ignored
      phase = "R7 out of range";
      got_q.delete();
      rej(2048);
      step(1'b1, offset - 32'd1, 1'b0, 1'b1);
      rej(5000);
      idle(1);
      step(1'b0, 32'd0, 1'b1, 1'b1);
      idle(1);
      chk("R7 no scan started", int'(busy), 0);
      idle(3);
      chk("R7 nothing replayed", got_q.size(), 0);

      // R8 R10: merge during scan, resend while busy ignored
      phase = "R8 R10 merge";
      got_q.delete();
      rej(3 * 64 + 5); rej(3 * 64 + 9); rej(10 * 64 + 1);
      idle(1);
      step(1'b0, 32'd0, 1'b1, 1'b1);
      idle(2);
      step(1'b1, offset + 32'(3 * 64 + 2), 1'b1, 1'b1);
      step(1'b1, offset + 32'(2 * 64 + 7), 1'b1, 1'b1);
      step(1'b1, offset + 32'(20 * 64), 1'b0, 1'b1);
      idle(60);
      exp_q = '{197, 201, 641, 1280};
      check_list("R8 R10 first pass", exp_q);
      got_q.delete();
      step(1'b0, 32'd0, 1'b1, 1'b1);
      idle(70);
      exp_q = '{135, 194};
      check_list("R8 entries behind scan wait", exp_q);

      // R9: back-pressure holds the offered retry
      phase = "R9 stall";
      got_q.delete();
      for (int k = 0; k < 10; k++) rej(7 * 64 + 3 * k);
      idle(1);
      step(1'b0, 32'd0, 1'b1, 1'b0);
      for (int k = 0; k < 80; k++) step(1'b0, 32'd0, 1'b0, 1'($urandom_range(0, 1)));
      idle(40);
      exp_q.delete();
      for (int k = 0; k < 10; k++) exp_q.push_back(7 * 64 + 3 * k);
      check_list("R9 all replayed in order", exp_q);

      // R6: reset in the middle of a scan discards everything
      phase = "R6 mid reset";
      rej(5); rej(900); rej(1500);
      idle(1);
      step(1'b0, 32'd0, 1'b1, 1'b0);
      idle(1);
      @(negedge clk);
      #1 rst_n = 1'b0;
      @(negedge clk);
      #1 rst_n = 1'b1;
      got_q.delete();
      step(1'b0, 32'd0, 1'b1, 1'b1);
      idle(1);
      chk("R6 cleared by reset busy", int'(busy), 0);
      idle(3);
      chk("R6 cleared by reset replay", got_q.size(), 0);

      // R8 R9 R10 soak with mixed traffic
      phase = "R8 R9 R10 soak";
      for (int k = 0; k < 3000; k++) begin
         step(1'($urandom_range(0, 1)), offset + 32'($urandom_range(0, 2200)),
              ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)));
      end
      step(1'b0, 32'd0, 1'b0, 1'b1);
      for (int k = 0; k < 4; k++) begin
         step(1'b0, 32'd0, 1'b1, 1'b1);
         idle(2600);
      end
      phase = "R2 soak drained";
      got_q.delete();
      step(1'b0, 32'd0, 1'b1, 1'b1);
      idle(200);
      chk("R2 soak fully drained", got_q.size(), 0);

      finish_run();
   end
endmodule